// File: doc/BRIEF.md
# Floppy Controller Host Register Front End

This block is the processor-facing register layer of a floppy disk controller. A small synchronous bus with a two-bit address, separate read and write strobes and byte-wide data reaches four locations. These are a general control register, a rate-select register, a read-only status byte and a command/result data port. The block also decides whether the first byte of each command is a known opcode. It hands known opcodes to the command sequencer and finishes unknown ones locally.

A power-down state gates the clock enables of three internal units: the data separator (bit 0), the internal microcontroller (bit 1) and the write precompensation unit (bit 2). Setting a single bit of the rate-select register enters this state at once. There are two ways back. A soft reset restores the clocks but clears the command state. An ordinary access to the status byte or the data port restores the clocks and keeps every register.

The block also turns the selected data rate and the perpendicular-recording enable into two lengths for the track formatter and the write path. The first is the length of the gap field laid down after the sector ID when a track is formatted. The second is how much of that gap a data write rewrites.

Top module: `fdc_host_front`

## Requirements
- R1: After the reset input, the status byte reads 0x80, the control register reads 0x04, the rate-select register reads 0x00, all three clock enables are 1, the interrupt is 0, and the gap lengths are 22 and 0.
- R2: Address map: 0 is control, 1 is rate-select, 2 is status and 3 is data. A write to address 1 with bit 6 set and bit 7 clear drops all three clock enables from the next cycle, with no handshake.
- R3: While powered down, any read or write of address 2 or 3 sets all clock enables again in the next cycle. That access is carried out normally, the read returns the current contents, and the control, rate-select, status and result contents are kept.
- R4: A soft reset clears power-down, the busy and result-pending status, the result byte and the interrupt. The status then reads 0x80 and the rate and control values are kept. It comes from a write to address 1 with bit 7 set, which wins over bit 6 in the same write, or from control bit 2 being 0.
- R5: While powered down, reads of address 0 or 1, control writes that keep bit 2 at 1, and writes to address 1 with bits 7 and 6 clear leave the clock enables at 0.
- R6: A first byte whose low five bits are 0, 1, 11 or 21 to 31 is undefined. Written while the status is 0x80, it makes the status 0xC0 (bits 7 and 6 set), raises no command start and leaves the interrupt unchanged. A read of address 3 then returns 0x80 and brings the status back to 0x80.
- R7: A defined first byte written while the status is 0x80 pulses the command start for one cycle with that opcode and makes the status 0x10 (bit 4 busy). The done input then sets the status back to 0x80 and raises the interrupt, which a status read clears.
- R8: Rate field bits 1:0 of address 1 code 00 as 500 kbps, 01 as 300 kbps, 10 as 250 kbps and 11 as 1 Mbps. Perpendicular recording is control bit 4. The format gap length is 41 for perpendicular at 1 Mbps and 22 otherwise.
- R9: The rewrite gap length is 0 with perpendicular recording off, 38 for perpendicular at 1 Mbps, and 19 for perpendicular at the other three rates.
- R10: Data writes while the status is not 0x80 (busy or a result pending) start nothing and leave the status unchanged.
- R11: While control bit 2 is 0, data writes start nothing and the status stays 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| unit_clk_en | output | 3 | Clock enables: separator, microcontroller, precompensation |
| irq | output | 1 | Command completion interrupt |
| cmd_start | output | 1 | One-cycle pulse for an accepted opcode |
| cmd_opcode | output | 8 | Accepted opcode |
| cmd_done | input | 1 | Sequencer signals end of the running command |
| fmt_gap_len | output | 6 | Format gap length in bytes |
| rw_gap_len | output | 6 | Gap bytes rewritten by a data write |

## Verification
Power-down entry and soft reset can arrive in the same cycle as one rate-select write with bits 7 and 6 both set. The bench issues exactly that write while a result is pending and the interrupt is high. It judges the outcome as reset winning: the clocks stay enabled, the status reads 0x80 and the interrupt drops. A wake-up access and a command byte also share one cycle, when a data write arrives during power-down. The bench expects the clocks back and the command start pulse in the same following cycle. A behavioural model, run alongside a long mixed stream of accesses and done pulses, judges every other overlap.

// File: rtl/fdc_fe_pkg.sv
package fdc_fe_pkg;

   localparam int BUS_W     = 8;
   localparam int CLK_UNITS = 3;

   typedef enum logic [1:0] {
      REG_CTL  = 2'd0,
      REG_RATE = 2'd1,
      REG_STAT = 2'd2,
      REG_DATA = 2'd3
   } reg_sel_e;

   localparam int CTL_RUN_BIT   = 2;
   localparam int CTL_PERP_BIT  = 4;
   localparam int RATE_RST_BIT  = 7;
   localparam int RATE_PD_BIT   = 6;

   localparam logic [1:0]       RATE_FAST      = 2'b11;
   localparam logic [BUS_W-1:0] UNKNOWN_RESULT = 8'h80;

   typedef struct packed {
      logic       ready;
      logic       to_host;
      logic       spare5;
      logic       busy;
      logic [3:0] spare;
   } stat_t;

   function automatic logic op_known(input logic [31:0] mask, input logic [BUS_W-1:0] op);
      return mask[op[4:0]];
   endfunction

endpackage

// File: rtl/fdc_fe_regs.sv
module fdc_fe_regs
   import fdc_fe_pkg::*;
#(
   parameter logic [BUS_W-1:0] CTL_RST  = 8'h04,
   parameter logic [1:0]       RATE_RST = 2'b00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic             wr_rate,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] ctl_q,
   output logic [1:0]       rate_q,
   output logic [3:0]       spare_q,
   output logic             run,
   output logic             perp,
   output logic             srst
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= CTL_RST;
         rate_q  <= RATE_RST;
         spare_q <= '0;
      end else begin
         if (wr_ctl) ctl_q <= wdata;
         if (wr_rate) begin
            rate_q  <= wdata[1:0];
            spare_q <= wdata[5:2];
         end
      end
   end

   assign run  = ctl_q[CTL_RUN_BIT];
   assign perp = ctl_q[CTL_PERP_BIT];
   // soft reset: held while the run bit is low, or pulsed by the rate register
   assign srst = !run || (wr_rate && wdata[RATE_RST_BIT]);

endmodule

// File: rtl/fdc_fe_power.sv
module fdc_fe_power
   import fdc_fe_pkg::*;
#(
   parameter bit REG_ENABLES = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 srst,
   input  logic                 pd_req,
   input  logic                 wake,
   output logic                 pd_q,
   output logic [CLK_UNITS-1:0] clk_en
);

   logic pd_d;

   always_comb begin
      if (srst)        pd_d = 1'b0;
      else if (wake)   pd_d = 1'b0;
      else if (pd_req) pd_d = 1'b1;
      else             pd_d = pd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pd_q <= 1'b0;
      else        pd_q <= pd_d;
   end

   for (genvar u = 0; u < CLK_UNITS; u++) begin : g_unit
      if (REG_ENABLES) begin : g_reg
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b1;
            else        en_q <= !pd_d;
         end
         assign clk_en[u] = en_q;
      end else begin : g_comb
         assign clk_en[u] = !pd_q;
      end
   end

endmodule

// File: rtl/fdc_fe_cmd.sv
module fdc_fe_cmd
   import fdc_fe_pkg::*;
#(
   parameter logic [31:0] VALID_MASK = 32'h001F_F7FC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             wr_data,
   input  logic             rd_data,
   input  logic             rd_stat,
   input  logic [BUS_W-1:0] wdata,
   input  logic             cmd_done,
   output stat_t            stat,
   output logic [BUS_W-1:0] result_q,
   output logic             irq,
   output logic             cmd_start,
   output logic [BUS_W-1:0] cmd_opcode
);

   logic ready_q, dir_q, busy_q;
   logic take, known;

   assign take  = wr_data && ready_q && !dir_q && !busy_q && !srst;
   assign known = op_known(VALID_MASK, wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q    <= 1'b1;
         dir_q      <= 1'b0;
         busy_q     <= 1'b0;
         result_q   <= '0;
         irq        <= 1'b0;
         cmd_start  <= 1'b0;
         cmd_opcode <= '0;
      end else if (srst) begin
         ready_q   <= 1'b1;
         dir_q     <= 1'b0;
         busy_q    <= 1'b0;
         result_q  <= '0;
         irq       <= 1'b0;
         cmd_start <= 1'b0;
      end else begin
         cmd_start <= take && known;
         if (take && known) begin
            busy_q     <= 1'b1;
            ready_q    <= 1'b0;
            cmd_opcode <= wdata;
         end else if (take) begin
            dir_q    <= 1'b1;
            result_q <= UNKNOWN_RESULT;
         end
         if (rd_data && dir_q) dir_q <= 1'b0;
         if (cmd_done && busy_q) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b1;
            irq     <= 1'b1;
         end else if (rd_stat) begin
            irq <= 1'b0;
         end
      end
   end

   always_comb begin
      stat         = '0;
      stat.ready   = ready_q;
      stat.to_host = dir_q;
      stat.busy    = busy_q;
   end

endmodule

// File: rtl/fdc_fe_gap.sv
module fdc_fe_gap
   import fdc_fe_pkg::*;
#(
   parameter int GAP_W         = 6,
   parameter int FMT_STD       = 22,
   parameter int FMT_PERP_FAST = 41,
   parameter int RW_PERP       = 19,
   parameter int RW_PERP_FAST  = 38
) (
   input  logic             perp,
   input  logic [1:0]       rate,
   output logic [GAP_W-1:0] fmt_len,
   output logic [GAP_W-1:0] rw_len
);

   logic fast;
   assign fast = (rate == RATE_FAST);

   always_comb begin
      fmt_len = GAP_W'(FMT_STD);
      rw_len  = '0;
      if (perp) begin
         rw_len = fast ? GAP_W'(RW_PERP_FAST) : GAP_W'(RW_PERP);
         if (fast) fmt_len = GAP_W'(FMT_PERP_FAST);
      end
   end

endmodule

// File: rtl/fdc_host_front.sv
module fdc_host_front
   import fdc_fe_pkg::*;
#(
   parameter logic [31:0]      VALID_MASK    = 32'h001F_F7FC,
   parameter logic [BUS_W-1:0] CTL_RST       = 8'h04,
   parameter logic [1:0]       RATE_RST      = 2'b00,
   parameter int               GAP_W         = 6,
   parameter int               FMT_STD       = 22,
   parameter int               FMT_PERP_FAST = 41,
   parameter int               RW_PERP       = 19,
   parameter int               RW_PERP_FAST  = 38,
   parameter bit               REG_ENABLES   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic [CLK_UNITS-1:0] unit_clk_en,
   output logic                 irq,
   output logic                 cmd_start,
   output logic [BUS_W-1:0]     cmd_opcode,
   input  logic                 cmd_done,
   output logic [GAP_W-1:0]     fmt_gap_len,
   output logic [GAP_W-1:0]     rw_gap_len
);

   localparam int GAP_MAX = (1 << GAP_W) - 1;

   if (GAP_W < 1 || FMT_STD > GAP_MAX || FMT_PERP_FAST > GAP_MAX ||
       RW_PERP > GAP_MAX || RW_PERP_FAST > GAP_MAX) begin : g_bad_gap
      $error("gap lengths do not fit GAP_W");
   end
   if (!CTL_RST[CTL_RUN_BIT]) begin : g_bad_ctl
      $error("control reset value must leave the run bit set");
   end

   logic wr_ctl, wr_rate, wr_data, rd_data, rd_stat, wake;
   logic [BUS_W-1:0] ctl_w, result_w;
   logic [1:0]       rate_w;
   logic [3:0]       spare_w;
   logic             run_w, perp_w, srst_w, pd_w;
   stat_t            stat_w;

   assign wr_ctl  = bus_wr && (bus_addr == REG_CTL);
   assign wr_rate = bus_wr && (bus_addr == REG_RATE);
   assign wr_data = bus_wr && (bus_addr == REG_DATA);
   assign rd_data = bus_rd && (bus_addr == REG_DATA);
   assign rd_stat = bus_rd && (bus_addr == REG_STAT);
   assign wake    = (bus_rd || bus_wr) && bus_addr[1];

   fdc_fe_regs #(.CTL_RST(CTL_RST), .RATE_RST(RATE_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctl  (wr_ctl),
      .wr_rate (wr_rate),
      .wdata   (bus_wdata),
      .ctl_q   (ctl_w),
      .rate_q  (rate_w),
      .spare_q (spare_w),
      .run     (run_w),
      .perp    (perp_w),
      .srst    (srst_w)
   );

   fdc_fe_power #(.REG_ENABLES(REG_ENABLES)) u_power (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst_w),
      .pd_req (wr_rate && bus_wdata[RATE_PD_BIT]),
      .wake   (wake),
      .pd_q   (pd_w),
      .clk_en (unit_clk_en)
   );

   fdc_fe_cmd #(.VALID_MASK(VALID_MASK)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .srst       (srst_w),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .rd_stat    (rd_stat),
      .wdata      (bus_wdata),
      .cmd_done   (cmd_done),
      .stat       (stat_w),
      .result_q   (result_w),
      .irq        (irq),
      .cmd_start  (cmd_start),
      .cmd_opcode (cmd_opcode)
   );

   fdc_fe_gap #(
      .GAP_W(GAP_W), .FMT_STD(FMT_STD), .FMT_PERP_FAST(FMT_PERP_FAST),
      .RW_PERP(RW_PERP), .RW_PERP_FAST(RW_PERP_FAST)
   ) u_gap (
      .perp    (perp_w),
      .rate    (rate_w),
      .fmt_len (fmt_gap_len),
      .rw_len  (rw_gap_len)
   );

   always_comb begin
      unique case (bus_addr)
         REG_CTL:  bus_rdata = ctl_w;
         REG_RATE: bus_rdata = {1'b0, pd_w, spare_w, rate_w};
         REG_STAT: bus_rdata = stat_w;
         default:  bus_rdata = result_w;
      endcase
   end

endmodule

// File: rtl/fdc_host_front_chk.sv
module fdc_host_front_chk #(
   parameter logic [31:0] VALID_MASK    = 32'h001F_F7FC,
   parameter int          GAP_W         = 6,
   parameter int          FMT_STD       = 22,
   parameter int          FMT_PERP_FAST = 41,
   parameter int          RW_PERP_FAST  = 38
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       bus_addr,
   input logic             bus_rd,
   input logic             bus_wr,
   input logic [7:0]       bus_wdata,
   input logic [2:0]       unit_clk_en,
   input logic             irq,
   input logic             cmd_start,
   input logic [GAP_W-1:0] fmt_gap_len,
   input logic [GAP_W-1:0] rw_gap_len,
   input logic             run,
   input logic             pd,
   input logic [7:0]       stat
);

   a_r2_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (run && bus_wr && bus_addr == 2'd1 && bus_wdata[6] && !bus_wdata[7]) |=> (unit_clk_en == 3'b000));

   a_r3_wake_access: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_clk_en == 3'b000 && (bus_rd || bus_wr) && bus_addr[1]) |=> (unit_clk_en == 3'b111));

   a_r4_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd1 && bus_wdata[7]) |=> (stat == 8'h80 && unit_clk_en == 3'b111 && !irq));

   a_r5_stay_down: assert property (@(posedge clk) disable iff (!rst_n)
      (pd && run && !((bus_rd || bus_wr) && bus_addr[1]) && !(bus_wr && bus_addr == 2'd1 && bus_wdata[7])
       && !(bus_wr && bus_addr == 2'd0 && !bus_wdata[2])) |=> pd);

   a_r6_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
      (run && bus_wr && bus_addr == 2'd3 && stat == 8'h80 && !VALID_MASK[bus_wdata[4:0]])
      |=> (stat == 8'hC0 && !cmd_start && irq == $past(irq)));

   a_r7_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> (stat == 8'h10));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);

   a_r8_fast_perp: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_gap_len == GAP_W'(FMT_PERP_FAST)) |-> (rw_gap_len == GAP_W'(RW_PERP_FAST)));

   a_r9_conventional: assert property (@(posedge clk) disable iff (!rst_n)
      (rw_gap_len == '0) |-> (fmt_gap_len == GAP_W'(FMT_STD)));

   a_r10_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (stat != 8'h80 && bus_wr && bus_addr == 2'd3) |=> !cmd_start);

endmodule

bind fdc_host_front fdc_host_front_chk #(
   .VALID_MASK(VALID_MASK), .GAP_W(GAP_W), .FMT_STD(FMT_STD),
   .FMT_PERP_FAST(FMT_PERP_FAST), .RW_PERP_FAST(RW_PERP_FAST)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_rd      (bus_rd),
   .bus_wr      (bus_wr),
   .bus_wdata   (bus_wdata),
   .unit_clk_en (unit_clk_en),
   .irq         (irq),
   .cmd_start   (cmd_start),
   .fmt_gap_len (fmt_gap_len),
   .rw_gap_len  (rw_gap_len),
   .run         (run_w),
   .pd          (pd_w),
   .stat        (stat_w)
);

// File: tb/tb_fdc_host_front.sv
`timescale 1ns/1ps
module tb_fdc_host_front;

   localparam logic [31:0] KNOWN = 32'h001F_F7FC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0, cmd_done = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata, cmd_opcode;
   logic [2:0] unit_clk_en;
   logic       irq, cmd_start;
   logic [5:0] fmt_gap_len, rw_gap_len;

   int checks = 0, failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   fdc_host_front dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unit_clk_en(unit_clk_en), .irq(irq),
      .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_done(cmd_done),
      .fmt_gap_len(fmt_gap_len), .rw_gap_len(rw_gap_len)
   );

   // behavioural reference model
   int m_ctl, m_rate, m_spare, m_pd, m_ready, m_dir, m_busy, m_res, m_irq, m_start, m_op;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = 4; m_rate = 0; m_spare = 0; m_pd = 0;
         m_ready = 1; m_dir = 0; m_busy = 0; m_res = 0; m_irq = 0; m_start = 0; m_op = 0;
      end else begin
         int a, d, sr, acc, busy0, dir0;
         a = bus_addr; d = bus_wdata; busy0 = m_busy; dir0 = m_dir;
         sr  = (((m_ctl >> 2) & 1) == 0) || (bus_wr && a == 1 && d[7]);
         acc = (bus_rd || bus_wr) && a >= 2;
         if (sr) m_pd = 0;
         else if (acc) m_pd = 0;
         else if (bus_wr && a == 1 && d[6]) m_pd = 1;
         if (bus_wr && a == 0) m_ctl = d;
         if (bus_wr && a == 1) begin m_rate = d & 3; m_spare = (d >> 2) & 15; end
         m_start = 0;
         if (sr) begin
            m_ready = 1; m_dir = 0; m_busy = 0; m_res = 0; m_irq = 0;
         end else begin
            if (bus_wr && a == 3 && m_ready && !dir0 && !busy0) begin
               if (KNOWN[d & 31]) begin m_busy = 1; m_ready = 0; m_start = 1; m_op = d; end
               else begin m_dir = 1; m_res = 8'h80; end
            end
            if (bus_rd && a == 3 && dir0) m_dir = 0;
            if (cmd_done && busy0) begin m_busy = 0; m_ready = 1; m_irq = 1; end
            else if (bus_rd && a == 2) m_irq = 0;
         end
      end
   end

   function automatic int m_stat();
      return (m_ready << 7) | (m_dir << 6) | (m_busy << 4);
   endfunction

   function automatic int m_read(int a);
      case (a)
         0: return m_ctl;
         1: return (m_pd << 6) | (m_spare << 2) | m_rate;
         2: return m_stat();
         default: return m_res;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int perp, fast;
      perp = (m_ctl >> 4) & 1; fast = (m_rate == 3);
      chk("R1/R6/R7 read data", bus_rdata, m_read(bus_addr));
      chk("R2/R3/R5 clock enables", unit_clk_en, m_pd ? 0 : 7);
      chk("R7 irq", irq, m_irq);
      chk("R7/R10 cmd_start", cmd_start, m_start);
      if (m_start) chk("R7 opcode", cmd_opcode, m_op);
      chk("R8 format gap", fmt_gap_len, (perp && fast) ? 41 : 22);
      chk("R9 rewrite gap", rw_gap_len, !perp ? 0 : (fast ? 38 : 19));
   endtask

   task automatic tick();
      @(negedge clk);
      if (rst_n) compare_all();
   endtask

   task automatic bw(int a, int d);
      bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic br(int a, output int v);
      bus_addr = 2'(a); bus_rd = 1'b1;
      #1 v = bus_rdata;
      tick();
      bus_rd = 1'b0;
   endtask

   task automatic done_pulse();
      cmd_done = 1'b1; tick(); cmd_done = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 clock enables", unit_clk_en, 7);
      chk("R1 irq", irq, 0);
      chk("R1 format gap", fmt_gap_len, 22);
      chk("R1 rewrite gap", rw_gap_len, 0);
      br(2, v); chk("R1 status", v, 8'h80);
      br(0, v); chk("R1 control", v, 8'h04);
      br(1, v); chk("R1 rate", v, 8'h00);

      // R8 and R9: every rate / recording mode pair
      for (int p = 0; p < 2; p++) begin
         for (int r = 0; r < 4; r++) begin
            bw(0, p ? 8'h14 : 8'h04);
            bw(1, r);
            chk("R8 format gap", fmt_gap_len, (p && r == 3) ? 41 : 22);
            chk("R9 rewrite gap", rw_gap_len, !p ? 0 : (r == 3 ? 38 : 19));
         end
      end
      bw(0, 8'h04); bw(1, 0);

      // R2 entry, R5 ignored accesses, R3 wake by status read
      bw(1, 8'h40);
      chk("R2 enables after power-down write", unit_clk_en, 0);
      br(0, v); br(1, v);
      chk("R5 rate readback keeps power-down bit", v, 8'h40);
      bw(1, 8'h03); bw(0, 8'h05);
      tick();
      chk("R5 enables stay low", unit_clk_en, 0);
      br(2, v);
      chk("R3 waking status read value", v, 8'h80);
      chk("R3 enables back", unit_clk_en, 7);
      br(1, v); chk("R3 rate kept", v, 8'h03);
      br(0, v); chk("R3 control kept", v, 8'h05);

      // R6 unknown opcode, retention through power-down, wake by data read
      bw(3, 8'h00);
      br(2, v); chk("R6 status after unknown", v, 8'hC0);
      chk("R6 no irq", irq, 0);
      bw(1, 8'h43);
      chk("R2 enables low", unit_clk_en, 0);
      br(2, v); chk("R3 pending status kept", v, 8'hC0);
      bw(1, 8'h43);
      br(3, v); chk("R6 result byte", v, 8'h80);
      chk("R3 enables back after data read", unit_clk_en, 7);
      br(2, v); chk("R6 status back to idle", v, 8'h80);
      bw(3, 8'h0B);
      br(2, v); chk("R6 opcode 11 unknown", v, 8'hC0);
      bw(3, 8'h05);
      chk("R10 no start while result pending", cmd_start, 0);
      br(2, v); chk("R10 status unchanged", v, 8'hC0);
      br(3, v);

      // R3 wake by data write that also starts a command; R7 and R10
      bw(1, 8'h40);
      bw(3, 8'h06);
      chk("R3 enables after waking write", unit_clk_en, 7);
      chk("R7 start pulse", cmd_start, 1);
      chk("R7 opcode", cmd_opcode, 8'h06);
      br(2, v); chk("R7 busy status", v, 8'h10);
      bw(3, 8'h07);
      chk("R10 no start while busy", cmd_start, 0);
      done_pulse();
      chk("R7 irq on done", irq, 1);
      br(2, v); chk("R7 status after done", v, 8'h80);
      chk("R7 irq cleared by status read", irq, 0);

      // R4 soft reset via rate write, colliding with power-down
      bw(0, 8'h14); bw(1, 8'h03);
      bw(3, 8'h08); done_pulse();
      bw(3, 8'h01);
      chk("R4 setup irq", irq, 1);
      bw(1, 8'hC3);
      chk("R4 reset wins over power-down", unit_clk_en, 7);
      chk("R4 irq cleared", irq, 0);
      chk("R4 perpendicular kept", fmt_gap_len, 41);
      br(2, v); chk("R4 status idle", v, 8'h80);
      br(3, v); chk("R4 result cleared", v, 8'h00);
      bw(1, 8'h43);
      bw(1, 8'h83);
      chk("R4 rate reset wakes", unit_clk_en, 7);

      // R4 / R11 soft reset through the control run bit
      bw(1, 8'h40);
      bw(0, 8'h10);
      tick();
      chk("R4 control reset wakes", unit_clk_en, 7);
      bw(3, 8'h06);
      chk("R11 no start while held", cmd_start, 0);
      br(2, v); chk("R11 status idle", v, 8'h80);
      bw(0, 8'h04);

      // mixed stream, judged by the model every cycle
      for (int i = 0; i < 3000; i++) begin
         int op, a, d;
         op = $urandom_range(0, 3); a = $urandom_range(0, 3); d = $urandom_range(0, 255);
         if (a == 0) d = d | 8'h04;
         cmd_done = ($urandom_range(0, 7) == 0);
         if (op == 1) begin bus_addr = 2'(a); bus_rd = 1'b1; end
         else if (op >= 2) begin bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1; end
         tick();
         bus_rd = 1'b0; bus_wr = 1'b0; cmd_done = 1'b0;
      end

      finished = 1;
      summary();
      $finish;
   end

endmodule